// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the bus-facing half of a 512-byte serial EEPROM. It runs on a fast system clock. It oversamples the two-wire bus lines (clock and data) through a short synchroniser and recognises START and STOP conditions. It also takes in the device select byte and moves bytes between the bus and the memory side. The data line is driven as an open-drain output enable. When `sda_oe` is high the line is pulled low, and it is released otherwise. The array and the program-cycle timer live outside the block. The block presents a 9-bit byte address for reads and sends each written byte, with its address, to an external write controller. At STOP it signals that controller to start a program cycle.

A select byte is accepted when bits 7..4 equal the device type `1010` and bits 3..2 equal `chip_sel[1:0]`. Bit 1 supplies the upper address bit and bit 0 gives the direction. After a write select, the next byte loads the low eight address bits, and every byte after that is a data byte. After a read select, the slave streams bytes from the internal counter until the master withholds its acknowledge. While the external program cycle is running, the slave does not acknowledge anything, so a master can poll with select bytes until one is acknowledged.

The state machine has these states:
- `ST_IDLE`: waiting for START.
- `ST_SEL`: receiving the select byte.
- `ST_SEL_ACK`: acknowledging the select byte.
- `ST_ADR`: receiving the address byte.
- `ST_ADR_ACK`: acknowledging the address byte.
- `ST_WR`: receiving a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD`: sending a data byte.
- `ST_RD_ACK`: sampling the master's acknowledge.

Transitions, taken on an SCL falling edge unless noted:
- STOP sends every state to `ST_IDLE`.
- START enters `ST_SEL`, or `ST_IDLE` while busy.
- `ST_SEL` goes to `ST_SEL_ACK` on a match, otherwise to `ST_IDLE`.
- `ST_SEL_ACK` goes to `ST_RD` for a read and to `ST_ADR` for a write.
- `ST_ADR` goes to `ST_ADR_ACK`, then to `ST_WR`.
- `ST_WR` goes to `ST_WR_ACK`, then back to `ST_WR`.
- `ST_RD` goes to `ST_RD_ACK`. From there it returns to `ST_RD` if the master acknowledged, otherwise to `ST_IDLE`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged, by pulling SDA low in the 9th clock, only when bits 7..4 are `1010` and bits 3..2 equal `chip_sel[1:0]`. Any other select byte gets no acknowledge, and the bytes that follow it are ignored until the next START.
- R2: Bit 1 of every accepted select byte replaces bit 8 of the address counter. Bit 0 is the direction: 1 for read, 0 for write.
- R3: START (SDA falls while SCL is high) restarts select-byte reception from any state, including in the middle of a transfer. STOP (SDA rises while SCL is high) returns the slave to idle.
- R4: `sda_oe` changes only while SCL is low. Incoming bits are taken on the SCL rising edge, MSB first.
- R5: In a write, the address byte is acknowledged and loads counter bits 7..0. Each following data byte is acknowledged and produces one `wr_en` pulse carrying the current counter value on `wr_addr` and the byte on `wr_data`. The counter then increments across all 9 bits.
- R6: A STOP that ends a transfer in which at least one data byte was accepted gives exactly one single-cycle `wr_commit` pulse. A STOP after a select-only or address-only write gives none.
- R7: While `prog_busy` is high, the slave acknowledges no select byte, never asserts `sda_oe` and issues no `wr_en`. Once `prog_busy` falls, a select byte is acknowledged again.
- R8: A random read works as follows. A write select and an address byte, then a repeated START and a read select, return the byte at the loaded address.
- R9: A current-address read returns the byte at {select bit 1, counter bits 7..0}, and the counter then increments.
- R10: While the master acknowledges, the slave sends consecutive bytes. The counter goes from 0x1FF to 0x000.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and stays off the bus until the next START.
- R12: After reset, `sda_oe`, `wr_en` and `wr_commit` are 0 and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| chip_sel | input | 2 | Expected select bits 3..2 |
| prog_busy | input | 1 | External program cycle in progress |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| sda_oe | output | 1 | Pull data line low when 1 |
| mem_addr | output | 9 | Current byte address counter |
| wr_en | output | 1 | One-cycle strobe per accepted data byte |
| wr_addr | output | 9 | Address of the strobed byte |
| wr_data | output | 8 | Data of the strobed byte |
| wr_commit | output | 1 | One-cycle request to start programming |

## Verification
The bench sweeps every pairing of chip-select pins against select bits, plus a wrong type code. A comparator that looks at too few bits would acknowledge a foreign select, and a slave that did not go deaf after a miss would acknowledge the next byte. Reads are aimed at both counter wrap points, 0x0FF to 0x100 and 0x1FF to 0x000. A counter that only advances the low byte, or that stops at the top, returns the wrong data there. Writes are followed straight away by acknowledge polling. A slave that answers while `prog_busy` is high, or that commits on a select-only transfer, shows a wrong acknowledge or an extra commit pulse. After a read without an acknowledge, the bench clocks another byte to catch a slave that keeps driving the line.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } ee_state_t;

endpackage

// File: rtl/i2c_ee_line_sync.sv
// Two-wire bus synchroniser and bus condition detector.
module i2c_ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_ee_addr_ctr.sv
// Byte address counter: upper bit and low byte loaded separately.
module i2c_ee_addr_ctr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_hi,
    input  logic          hi_bit,
    input  logic          load_lo,
    input  logic [AW-2:0] lo_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (inc)     addr_d = addr_q + 1'b1;
        if (load_lo) addr_d[AW-2:0] = lo_val;
        if (load_hi) addr_d[AW-1] = hi_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int         ADDR_W      = 9,
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        chip_sel,
    input  logic              prog_busy,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    ee_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sreg;
    logic [BYTE_W-1:0] tx_q;
    logic              rw_q;
    logic              mack_q;
    logic              pend_q;
    logic              oe_q;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic byte_done, sel_hit;
    logic ld_hi, ld_lo, ctr_inc;

    i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign sel_hit   = (sreg[7:4] == DEV_TYPE) && (sreg[3:2] == chip_sel);
    assign ld_hi     = scl_fall && !stop_evt && !start_evt && (state_q == ST_SEL)
                       && byte_done && sel_hit && !prog_busy;
    assign ld_lo     = scl_fall && (state_q == ST_ADR) && byte_done;
    assign ctr_inc   = scl_fall && byte_done && ((state_q == ST_WR) || (state_q == ST_RD));

    i2c_ee_addr_ctr #(.AW(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (ld_hi),
        .hi_bit  (sreg[1]),
        .load_lo (ld_lo),
        .lo_val  (sreg[ADDR_W-2:0]),
        .inc     (ctr_inc),
        .addr    (mem_addr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = prog_busy ? ST_IDLE : ST_SEL;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SEL:     if (byte_done) state_d = (sel_hit && !prog_busy) ? ST_SEL_ACK : ST_IDLE;
                ST_SEL_ACK: state_d = rw_q ? ST_RD : ST_ADR;
                ST_ADR:     if (byte_done) state_d = ST_ADR_ACK;
                ST_ADR_ACK: state_d = ST_WR;
                ST_WR:      if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:  state_d = ST_WR;
                ST_RD:      if (byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:  state_d = mack_q ? ST_RD : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q      <= 1'b0;
            bit_cnt   <= '0;
            sreg      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            pend_q    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            wr_commit <= 1'b0;
            if (stop_evt) begin
                oe_q    <= 1'b0;
                bit_cnt <= '0;
                if (pend_q) begin
                    wr_commit <= 1'b1;
                    pend_q    <= 1'b0;
                end
            end else if (start_evt) begin
                oe_q    <= 1'b0;
                bit_cnt <= '0;
            end else begin
                if (scl_rise) begin
                    if (state_q inside {ST_SEL, ST_ADR, ST_WR}) begin
                        sreg    <= {sreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (state_q == ST_RD) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (state_q == ST_RD_ACK) begin
                        mack_q <= ~sda_s;
                    end
                end
                if (scl_fall) begin
                    unique case (state_q)
                        ST_SEL: if (byte_done) begin
                            bit_cnt <= '0;
                            if (sel_hit && !prog_busy) begin
                                oe_q <= 1'b1;
                                rw_q <= sreg[0];
                            end
                        end
                        ST_SEL_ACK: begin
                            if (rw_q) begin
                                tx_q <= mem_rdata;
                                oe_q <= ~mem_rdata[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                        ST_ADR: if (byte_done) begin
                            bit_cnt <= '0;
                            oe_q    <= 1'b1;
                        end
                        ST_ADR_ACK: oe_q <= 1'b0;
                        ST_WR: if (byte_done) begin
                            bit_cnt <= '0;
                            oe_q    <= 1'b1;
                            wr_en   <= 1'b1;
                            wr_addr <= mem_addr;
                            wr_data <= sreg;
                            pend_q  <= 1'b1;
                        end
                        ST_WR_ACK: oe_q <= 1'b0;
                        ST_RD: begin
                            if (byte_done) begin
                                bit_cnt <= '0;
                                oe_q    <= 1'b0;
                            end else begin
                                oe_q <= ~tx_q[BYTE_W-2];
                                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                        ST_RD_ACK: begin
                            if (mack_q) begin
                                tx_q <= mem_rdata;
                                oe_q <= ~mem_rdata[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                        default: oe_q <= 1'b0;
                    endcase
                end
            end
        end
    end

    assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic prog_busy,
    input logic sda_oe,
    input logic wr_en,
    input logic wr_commit
);
    // R4: the open-drain enable only moves while the bus clock is low
    assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R7: silent and not writing during a program cycle
    assert_silent_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (!sda_oe && !wr_en));

    // R6: commit is a single-cycle pulse
    assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R6: commit only comes from STOP, which happens with SCL high
    assert_commit_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> scl_i);

    // R5: data strobes come from a falling bus clock, never with a commit
    assert_wr_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!scl_i && !wr_commit));

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .prog_busy (prog_busy),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_commit (wr_commit)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
    localparam int H        = 20;
    localparam int BUSY_CYC = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] chip_sel = 2'b10;
    logic       prog_busy;
    logic       sda_oe;
    logic [8:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_commit;
    wire        sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    logic [7:0] mem     [0:511];
    logic [7:0] exp_mem [0:511];
    logic [8:0] pa [0:15];
    logic [7:0] pd [0:15];
    int         pn;
    int         busy_cnt;
    logic [8:0] log_a [0:63];
    logic [7:0] log_d [0:63];
    int         tot_wr;
    int         tot_cm;
    int         tests = 0;
    int         fails = 0;
    logic [8:0] cur;

    assign mem_rdata = mem[mem_addr];
    assign prog_busy = (busy_cnt != 0);

    i2c_eeprom_slave u_i2c_eeprom_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .chip_sel  (chip_sel),
        .prog_busy (prog_busy),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    // Write controller and array model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
            pn       <= 0;
            busy_cnt <= 0;
            tot_wr   <= 0;
            tot_cm   <= 0;
        end else begin
            if (wr_en) begin
                pa[pn[3:0]] <= wr_addr;
                pd[pn[3:0]] <= wr_data;
                pn          <= pn + 1;
                log_a[tot_wr[5:0]] <= wr_addr;
                log_d[tot_wr[5:0]] <= wr_data;
                tot_wr      <= tot_wr + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < 16; i++)
                    if (i < pn) mem[pa[i]] <= pd[i];
                pn       <= 0;
                busy_cnt <= BUSY_CYC;
                tot_cm   <= tot_cm + 1;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl_m = 1'b1; wt(H);
            scl_m = 1'b0; wt(4);
        end
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H / 2);
        ack = !sda_bus;
        wt(H / 2);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
        logic [7:0] v = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            scl_m = 1'b1; wt(H / 2);
            v = {v[6:0], sda_bus};
            wt(H / 2);
            scl_m = 1'b0; wt(4);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(4);
        sda_m = 1'b1;
        b = v;
    endtask

    task automatic sel(input logic a8, input logic rw, output bit ack);
        m_wbyte({4'b1010, chip_sel, a8, rw}, ack);
    endtask

    // Random read (R8) followed by sequential bytes (R10)
    task automatic rd_seq(input logic [8:0] a, input int n, input string req);
        bit ack;
        logic [7:0] d;
        logic [8:0] ea;
        m_start();
        sel(a[8], 1'b0, ack);
        chk(ack, "R1 select ack", ack, 1);
        m_wbyte(a[7:0], ack);
        chk(ack, "R5 address ack", ack, 1);
        m_start();
        sel(a[8], 1'b1, ack);
        chk(ack, "R3 select after repeated START", ack, 1);
        for (int k = 0; k < n; k++) begin
            m_rbyte(k < n - 1, d);
            ea = a + 9'(k);
            chk(d == exp_mem[ea], req, d, exp_mem[ea]);
        end
        m_stop();
        cur = a + 9'(n);
    endtask

    // Current-address read (R9)
    task automatic rd_cur(input logic a8);
        bit ack;
        logic [7:0] d;
        logic [8:0] ea;
        ea = {a8, cur[7:0]};
        m_start();
        sel(a8, 1'b1, ack);
        chk(ack, "R9 read select ack", ack, 1);
        m_rbyte(1'b0, d);
        m_stop();
        chk(d == exp_mem[ea], "R9 current-address data", d, exp_mem[ea]);
        cur = ea + 9'd1;
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] seed);
        bit ack;
        int base_w;
        int base_c;
        int tries;
        logic [7:0] d;
        base_w = tot_wr;
        base_c = tot_cm;
        m_start();
        sel(a[8], 1'b0, ack);
        chk(ack, "R1 write select ack", ack, 1);
        m_wbyte(a[7:0], ack);
        chk(ack, "R5 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 17);
            m_wbyte(d, ack);
            chk(ack, "R5 data ack", ack, 1);
            exp_mem[a + 9'(k)] = d;
        end
        m_stop();
        wt(4);
        chk(tot_wr - base_w == n, "R5 strobe count", tot_wr - base_w, n);
        for (int k = 0; k < n; k++) begin
            chk(log_a[6'(base_w + k)] == a + 9'(k), "R5 strobe address",
                log_a[6'(base_w + k)], a + 9'(k));
            chk(log_d[6'(base_w + k)] == seed + 8'(k * 17), "R5 strobe data",
                log_d[6'(base_w + k)], seed + 8'(k * 17));
        end
        chk(tot_cm - base_c == 1, "R6 one commit on STOP", tot_cm - base_c, 1);
        // Acknowledge polling
        m_start();
        sel(1'b0, 1'b0, ack);
        m_stop();
        chk(!ack, "R7 no ack while busy", ack, 0);
        tries = 0;
        do begin
            m_start();
            sel(1'b0, 1'b0, ack);
            m_stop();
            tries++;
        end while (!ack && tries < 30);
        chk(ack, "R7 ack after program cycle", ack, 1);
        chk(tot_cm - base_c == 1, "R6 no commit for select-only write", tot_cm - base_c, 1);
        cur = {1'b0, 8'(a + 9'(n))};
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'(i * 7 + 3);
        cur = '0;
        wt(5);
        // R12 reset state
        chk(sda_oe == 1'b0, "R12 sda_oe in reset", sda_oe, 0);
        chk(wr_en == 1'b0, "R12 wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        wt(5);
        chk(wr_commit == 1'b0, "R12 wr_commit after reset", wr_commit, 0);
        // R12: counter starts at 0, seen by a current-address read
        rd_cur(1'b0);

        // R1 sweep: select bits against pins
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 4; e++) begin
                chip_sel = 2'(p);
                m_start();
                m_wbyte({4'b1010, 2'(e), 1'b0, 1'b0}, ack);
                m_stop();
                chk(ack == (p == e), "R1 select match", ack, (p == e));
                if (p == e) cur[8] = 1'b0;
            end
        end
        chip_sel = 2'b10;
        m_start();
        m_wbyte({4'b1011, chip_sel, 2'b00}, ack);
        chk(!ack, "R1 wrong type code", ack, 0);
        m_wbyte(8'h00, ack);
        chk(!ack, "R1 ignored until START", ack, 0);
        m_stop();

        // R8 random reads in both blocks, R2 upper bit from select
        rd_seq(9'h033, 1, "R8 random read low block");
        rd_seq(9'h133, 1, "R2 random read upper block");
        rd_cur(1'b1);

        // R5/R6/R7 writes, R2 block choice
        do_write(9'h105, 1, 8'h5A);
        rd_seq(9'h105, 1, "R2 byte written in upper block");
        rd_seq(9'h005, 1, "R2 lower block untouched");
        do_write(9'h0FE, 4, 8'hC3);
        rd_seq(9'h0FC, 8, "R10 sequential across 0FF to 100");

        // R10 rollover at the top
        rd_seq(9'h1FE, 4, "R10 rollover 1FF to 000");
        rd_cur(1'b0);

        // R11: after a NACK the slave stays off the bus
        rd_seq(9'h040, 1, "R8 random read before NACK");
        m_rbyte(1'b0, d);
        chk(d == 8'hFF, "R11 released after NACK", d, 8'hFF);
        m_stop();
        rd_cur(1'b0);

        wt(20);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

endmodule